// File: doc/BRIEF.md
# Rate-Dependent Channel Sample Interleaver

This block takes one channel vector per fast clock cycle and packs successive vectors into memory words whose layout follows a run-time rate mode. In the base mode every word is a single sample of all channels. In each faster mode the word holds a group of consecutive samples of fewer channels. Mode m groups 2^m samples of `CH_W >> m` channels. With the default parameters this gives one sample of 16 channels, two samples of 8 channels, or four samples of 4 channels.

Bits are interleaved by channel. Each channel's samples sit side by side, oldest first, rather than in one contiguous field per sample. A strobe marks each finished word, so the strobe rate equals the fast clock rate divided by the group size. The stream feeding the memory stays at a fixed word width while the channel count is traded for time resolution.

When the mode changes, any partly built group is discarded and packing restarts on a fresh group boundary.

Top module: `rate_interleaver`

## Requirements
- R1: With `mode_i` = 0 (group size 1), every cycle's `smp_i` appears unchanged on `word_o` one clock later, and `vld_o` is high in that cycle.
- R2: With `mode_i` = 1 (group size 2, 8 channels), bit 2*c+k of a finished word holds channel c of the k-th sample of the group. k = 0 is the oldest sample.
- R3: With `mode_i` = 2 (group size 4, 4 channels), bit 4*c+k of a finished word holds channel c of the k-th sample of the group. k = 0 is the oldest sample.
- R4: In a mode with group size N, `vld_o` is high for exactly one cycle in every N cycles. It rises one clock after the cycle that supplies the group's last sample.
- R5: A cycle whose effective mode differs from the previous cycle's starts a new group with that cycle's sample as sample 0. The unfinished group of the old mode produces no strobe.
- R6: In a mode with group size N, channels at index `CH_W/N` and above have no effect on `word_o`.
- R7: After reset, `word_o` is 0 and `vld_o` is 0, and the previous mode counts as 0. A first active cycle with `mode_i` = 0 produces a word one clock later.
- R8: The unused mode value 3 behaves exactly like mode 0.
- R9: Between strobes, `word_o` keeps the last finished word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | MODE_W | Rate mode: 0 one sample, 1 two samples, 2 four samples, 3 as 0 |
| smp_i | input | CH_W | Channel vector sampled this cycle, bit c is channel c |
| word_o | output | CH_W | Last finished packed word |
| vld_o | output | 1 | One-cycle strobe marking a new word on `word_o` |

## Verification
The bench builds the block with its defaults: 16 channels and three rate modes, plus the spare mode code. These reach every group size up to four, the reserved code, and the discarding of partial groups at each mode change.

Random phases hold a mode for tens of cycles, then switch to any of the four codes, so groups are cut at every possible phase. Directed sequences pin down the bit positions with upper channels toggling, a switch in the middle of a group, and the first cycle after reset.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  function automatic int unsigned grp_len(input int unsigned m);
    return 32'd1 << m;
  endfunction

  function automatic int unsigned lane_cnt(input int unsigned w, input int unsigned m);
    return w >> m;
  endfunction
endpackage

// File: rtl/ilv_rate_ctl.sv
module ilv_rate_ctl #(
  parameter int MODE_W       = 2,
  parameter int MAX_RATE_LOG = 2,
  parameter int PH_W         = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  output logic [MODE_W-1:0] mode_eff_o,
  output logic              restart_o,
  output logic [PH_W-1:0]   phase_o,
  output logic              last_o
);
  logic [MODE_W-1:0] mode_q;
  logic [PH_W-1:0]   phase_q;
  logic [PH_W-1:0]   last_ph;

  // codes beyond the deepest mode fall back to the base mode
  assign mode_eff_o = (mode_i > MODE_W'(MAX_RATE_LOG)) ? '0 : mode_i;
  assign restart_o  = (mode_eff_o != mode_q);
  assign phase_o    = restart_o ? '0 : phase_q;
  assign last_ph    = PH_W'(ilv_pkg::grp_len(32'(mode_eff_o)) - 32'd1);
  assign last_o     = (phase_o == last_ph);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      phase_q <= '0;
    end else begin
      mode_q  <= mode_eff_o;
      phase_q <= last_o ? '0 : phase_o + PH_W'(1);
    end
  end
endmodule

// File: rtl/ilv_scatter.sv
module ilv_scatter #(
  parameter int CH_W         = 16,
  parameter int MAX_RATE_LOG = 2,
  parameter int MODE_W       = 2,
  parameter int PH_W         = 2
) (
  input  logic [CH_W-1:0]   smp_i,
  input  logic [MODE_W-1:0] mode_eff_i,
  input  logic [PH_W-1:0]   phase_i,
  output logic [CH_W-1:0]   bits_o,
  output logic [CH_W-1:0]   mask_o
);
  localparam int MODES = MAX_RATE_LOG + 1;

  logic [MODES-1:0][CH_W-1:0] bits_m;
  logic [MODES-1:0][CH_W-1:0] mask_m;

  for (genvar m = 0; m < MODES; m++) begin : g_mode
    localparam int N     = ilv_pkg::grp_len(m);
    localparam int LANES = ilv_pkg::lane_cnt(CH_W, m);
    for (genvar c = 0; c < LANES; c++) begin : g_lane
      for (genvar k = 0; k < N; k++) begin : g_slot
        assign bits_m[m][c*N+k] = smp_i[c];
        assign mask_m[m][c*N+k] = (phase_i == PH_W'(k));
      end
    end
  end

  always_comb begin
    bits_o = '0;
    mask_o = '0;
    for (int i = 0; i < MODES; i++) begin
      if (mode_eff_i == MODE_W'(i)) begin
        bits_o = bits_m[i];
        mask_o = mask_m[i];
      end
    end
  end
endmodule

// File: rtl/rate_interleaver.sv
module rate_interleaver #(
  parameter int CH_W         = 16,
  parameter int MAX_RATE_LOG = 2,
  parameter int MODE_W       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [CH_W-1:0]   smp_i,
  output logic [CH_W-1:0]   word_o,
  output logic              vld_o
);
  localparam int PH_W = (MAX_RATE_LOG > 0) ? MAX_RATE_LOG : 1;

  logic [MODE_W-1:0] mode_eff;
  logic              restart;
  logic [PH_W-1:0]   phase;
  logic              last;
  logic [CH_W-1:0]   bits, mask, acc_q, merged;

  ilv_rate_ctl #(
    .MODE_W(MODE_W), .MAX_RATE_LOG(MAX_RATE_LOG), .PH_W(PH_W)
  ) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .mode_eff_o(mode_eff), .restart_o(restart),
    .phase_o(phase), .last_o(last)
  );

  ilv_scatter #(
    .CH_W(CH_W), .MAX_RATE_LOG(MAX_RATE_LOG), .MODE_W(MODE_W), .PH_W(PH_W)
  ) u_scatter (
    .smp_i(smp_i), .mode_eff_i(mode_eff), .phase_i(phase),
    .bits_o(bits), .mask_o(mask)
  );

  // slot 0 opens a clean word; later slots fill their own bit positions
  assign merged = (((phase == '0) ? '0 : acc_q) & ~mask) | (bits & mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      word_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      acc_q <= merged;
      vld_o <= last;
      if (last) word_o <= merged;
    end
  end
endmodule

// File: rtl/ilv_chk.sv
module ilv_chk #(
  parameter int CH_W   = 16,
  parameter int MODE_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [MODE_W-1:0] mode_eff,
  input logic              restart,
  input logic [CH_W-1:0]   smp_i,
  input logic [CH_W-1:0]   word_o,
  input logic              vld_o
);
  AST_BASE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_eff == '0) |=> vld_o); // R1

  AST_BASE_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_eff == '0) |=> (word_o == $past(smp_i))); // R1

  AST_RESTART_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart && mode_eff != '0) |=> !vld_o); // R5

  AST_STROBE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && $past(vld_o)) |-> ($past(mode_eff) == '0)); // R4

  AST_HOLD_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> $stable(word_o)); // R9

  AST_VLD_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(vld_o)); // R4
endmodule

bind rate_interleaver ilv_chk #(.CH_W(CH_W), .MODE_W(MODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_eff(mode_eff), .restart(restart),
  .smp_i(smp_i), .word_o(word_o), .vld_o(vld_o)
);

// File: tb/tb_rate_interleaver.sv
`timescale 1ns/1ps
module tb_rate_interleaver;
  localparam int CH_W = 16;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [1:0]      mode_i = '0;
  logic [CH_W-1:0] smp_i = '0;
  logic [CH_W-1:0] word_o;
  logic            vld_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int              m_prev;
  int              cnt;
  logic [CH_W-1:0] hist [4];
  logic [CH_W-1:0] held;

  always #2 clk_i = ~clk_i;

  rate_interleaver dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .smp_i(smp_i), .word_o(word_o), .vld_o(vld_o)
  );

  function automatic logic [CH_W-1:0] pack(input int e);
    logic [CH_W-1:0] w = '0;
    int n = 1 << e;
    for (int c = 0; c < (CH_W >> e); c++)
      for (int k = 0; k < n; k++)
        w[c*n+k] = hist[k][c];
    return w;
  endfunction

  task automatic step(input logic [1:0] m, input logic [CH_W-1:0] s, input string tag);
    int e = (m > 2) ? 0 : int'(m);
    int n = 1 << e;
    logic exp_v;
    string t;
    if (e != m_prev) cnt = 0;
    m_prev = e;
    hist[cnt] = s;
    mode_i = m;
    smp_i  = s;
    if (cnt == n - 1) begin
      exp_v = 1'b1;
      held  = pack(e);
      cnt   = 0;
    end else begin
      exp_v = 1'b0;
      cnt++;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    if (tag != "") t = tag;
    else if (!exp_v) t = "R4 R9";
    else t = (e == 0) ? "R1" : (e == 1) ? "R2" : "R3";
    checks++;
    if (vld_o !== exp_v || word_o !== held) begin
      fails++;
      $display("FAIL %s: vld=%0b word=%h expected vld=%0b word=%h",
               t, vld_o, word_o, exp_v, held);
    end
  endtask

  initial begin
    int cur_m;
    void'($urandom(32'h5eed_1234));
    m_prev = 0; cnt = 0; held = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    checks++;
    if (word_o !== '0 || vld_o !== 1'b0) begin
      fails++;
      $display("FAIL R7: vld=%0b word=%h expected vld=0 word=0000", vld_o, word_o);
    end
    // first cycle in base mode emits at once
    step(2'd0, 16'hBEEF, "R7");
    step(2'd0, 16'h1234, "R1");
    // double mode: upper byte toggles but must not matter
    step(2'd1, 16'hFF5A, "R6");
    step(2'd1, 16'h00A5, "R6");
    step(2'd1, 16'h005A, "R6");
    step(2'd1, 16'hC3A5, "R6");
    // quad mode with upper lanes noisy
    step(2'd2, 16'hFFF1, "R3");
    step(2'd2, 16'h0A02, "R3");
    step(2'd2, 16'h7B04, "R3");
    step(2'd2, 16'h0C08, "R3");
    // cut a quad group after two samples
    step(2'd2, 16'h000F, "R5");
    step(2'd2, 16'h0003, "R5");
    step(2'd1, 16'h0081, "R5");
    step(2'd1, 16'h0042, "R5");
    // reserved code equals base mode
    step(2'd3, 16'hA55A, "R8");
    step(2'd3, 16'h0F0F, "R8");
    step(2'd2, 16'h0001, "R9");
    step(2'd2, 16'h0002, "R9");
    step(2'd2, 16'h0004, "R9");
    step(2'd2, 16'h0008, "R9");
    cur_m = 1;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 24 == 0) cur_m = $urandom % 4;
      step(2'(cur_m), CH_W'($urandom), "");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule